// File: doc/BRIEF.md
# Disk Channel Interrupt Cause Controller

This block gathers the interrupt causes of a single disk channel into one status register and drives a single interrupt line towards the host. It tracks two causes: one comes from the attached drive and one comes from the DMA engine when a memory access faults. When the fault cause sets, the block also stores the 64-bit memory address that faulted. Software reads that address back as two 32-bit words.

Software reaches the block through a simple word-indexed register port. The writes are separate for setting and for clearing. A write-1-to-set word turns on interrupt enables. A write-1-to-clear word drops pending causes. The drive cause can also be dropped without a register write. The channel's status-register read path signals that the drive's status register was read, and that read acknowledges the drive interrupt.

Top module: `irq_cause_ctrl`

## Requirements
- R1: After reset, every cause bit and enable bit is 0, the stored fault address is 0 and `irq_out` is low.
- R2: A read at word index 3 returns the cause bits and zeros above them. Bit 0 is the drive cause and bit 1 is the memory-fault cause. A pulse on `dev_evt` sets bit 0 and a pulse on `mem_err_evt` sets bit 1, each on the next clock.
- R3: A write at word index 5 ORs `reg_wdata[1:0]` into the enable bits, and a 0 in a bit leaves that enable unchanged. A read at index 5 returns the enables.
- R4: A write at word index 7 clears every cause bit whose `reg_wdata` bit is 1, so writing 0x3 clears both. A read at index 7 returns 0.
- R5: When a cause event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: A `stat_rd` pulse clears cause bit 0 on the next clock and never touches cause bit 1.
- R7: When `mem_err_evt` arrives while cause bit 1 is clear, `mem_err_addr` is stored. Its low word reads at index 0 and its high word at index 1.
- R8: While cause bit 1 is set, further faults do not replace the stored address.
- R9: `irq_out` is high exactly when a cause bit and its enable bit are both 1. It stays high until a clear write or `stat_rd` removes the enabled causes.
- R10: Writes at index 3 and at unused indices (2, 4, 6) change nothing. Reads at unused indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Word index of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, from the current register state |
| dev_evt | input | 1 | Drive interrupt event pulse |
| mem_err_evt | input | 1 | DMA memory-fault event pulse |
| mem_err_addr | input | 64 | Faulting memory address, valid with `mem_err_evt` |
| stat_rd | input | 1 | Drive status register was read (acknowledges drive cause) |
| irq_out | output | 1 | Interrupt request to the host |

## Verification
The assertions take for granted that `mem_err_addr` is valid whenever `mem_err_evt` is high. They also assume that every input is 0 while reset is held, so no event or clear is pending when reset is released. The stimulus holds all inputs at zero through reset. It then changes inputs only on the falling edge, drawing events, strobes, clear masks and addresses at random. Extra random bits sit above the cause bits in the write data, so the block has to ignore them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NCAUSE     = 2;
    localparam int IDX_ERR_LO = 0;
    localparam int IDX_ERR_HI = 1;
    localparam int IDX_STATUS = 3;
    localparam int IDX_ENABLE = 5;
    localparam int IDX_CLEAR  = 7;

    typedef struct packed {
        logic [NCAUSE-1:0] cause;
        logic [NCAUSE-1:0] enable;
    } irqc_flags_t;
endpackage

// File: rtl/irqc_cause.sv
module irqc_cause
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCAUSE-1:0] evt,
    input  logic [NCAUSE-1:0] side_clr,
    input  logic              set_en_wr,
    input  logic              clr_wr,
    input  logic [NCAUSE-1:0] wmask,
    output logic [NCAUSE-1:0] cause_q,
    output logic [NCAUSE-1:0] enable_q
);
    irqc_flags_t st_d, st_q;
    logic [NCAUSE-1:0] clr_mask;

    always_comb begin
        st_d     = st_q;
        clr_mask = clr_wr ? wmask : '0;
        if (set_en_wr) st_d.enable = st_q.enable | wmask;
        st_d.cause = evt | (st_q.cause & ~clr_mask & ~side_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cause_q  = st_q.cause;
    assign enable_q = st_q.enable;

    assert_dev_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt[0] |=> cause_q[0]);
    assert_err_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt[1] |=> cause_q[1]);
    assert_enable_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        enable_q[0] |=> enable_q[0]);
    assert_clear_bit0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wmask[0] && !evt[0]) |=> !cause_q[0]);
    assert_event_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && wmask[1] && evt[1]) |=> cause_q[1]);
    assert_side_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (side_clr[0] && !evt[0]) |=> !cause_q[0]);
endmodule

// File: rtl/irqc_errcap.sv
module irqc_errcap #(
    parameter int ERR_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [ERR_W-1:0] addr_in,
    output logic [ERR_W-1:0] addr_q
);
    typedef struct packed {
        logic [ERR_W-1:0] addr;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (capture) cap_d.addr = addr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign addr_q = cap_q.addr;
endmodule

// File: rtl/irqc_rdmux.sv
module irqc_rdmux
    import irqc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int ERR_W  = 64
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [NCAUSE-1:0] cause,
    input  logic [NCAUSE-1:0] enable,
    input  logic [ERR_W-1:0]  err_addr,
    output logic [DATA_W-1:0] rdata
);
    localparam int NWORDS = (ERR_W + DATA_W - 1) / DATA_W;
    localparam int PAD_W  = NWORDS * DATA_W;

    logic [PAD_W-1:0] err_pad;
    logic [DATA_W-1:0] err_word [NWORDS];

    assign err_pad = PAD_W'(err_addr);

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign err_word[w] = err_pad[w*DATA_W +: DATA_W];
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(IDX_ERR_LO))      rdata = err_word[0];
        else if (addr == ADDR_W'(IDX_ERR_HI)) rdata = err_word[NWORDS-1];
        else if (addr == ADDR_W'(IDX_STATUS)) rdata = DATA_W'(cause);
        else if (addr == ADDR_W'(IDX_ENABLE)) rdata = DATA_W'(enable);
    end
endmodule

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
    import irqc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int ERR_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dev_evt,
    input  logic              mem_err_evt,
    input  logic [ERR_W-1:0]  mem_err_addr,
    input  logic              stat_rd,
    output logic              irq_out
);
    logic [NCAUSE-1:0] cause_q, enable_q;
    logic [ERR_W-1:0]  err_addr_q;
    logic              wr_set, wr_clr, first_err;

    assign wr_set    = reg_wr && (reg_addr == ADDR_W'(IDX_ENABLE));
    assign wr_clr    = reg_wr && (reg_addr == ADDR_W'(IDX_CLEAR));
    assign first_err = mem_err_evt && !cause_q[1];

    irqc_cause u_cause (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       ({mem_err_evt, dev_evt}),
        .side_clr  ({1'b0, stat_rd}),
        .set_en_wr (wr_set),
        .clr_wr    (wr_clr),
        .wmask     (reg_wdata[NCAUSE-1:0]),
        .cause_q   (cause_q),
        .enable_q  (enable_q)
    );

    irqc_errcap #(.ERR_W(ERR_W)) u_errcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (first_err),
        .addr_in (mem_err_addr),
        .addr_q  (err_addr_q)
    );

    irqc_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ERR_W(ERR_W)) u_rdmux (
        .addr     (reg_addr),
        .cause    (cause_q),
        .enable   (enable_q),
        .err_addr (err_addr_q),
        .rdata    (reg_rdata)
    );

    assign irq_out = |(cause_q & enable_q);

    assert_addr_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_q[1]) |-> (err_addr_q == $past(mem_err_addr)));
    assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cause_q[1] |=> $stable(err_addr_q));
    assert_irq_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !wr_clr && !stat_rd) |=> irq_out);
    assert_side_keeps_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q[1] && !wr_clr) |=> cause_q[1]);
endmodule

// File: tb/sim_irq_cause_ctrl.sv
module sim_irq_cause_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_evt = 1'b0;
    logic        mem_err_evt = 1'b0;
    logic [63:0] mem_err_addr = '0;
    logic        stat_rd = 1'b0;
    logic        irq_out;

    int total = 0;
    int fails = 0;
    bit finished = 1'b0;

    logic [1:0]  m_cause = '0;
    logic [1:0]  m_en = '0;
    logic [63:0] m_err = '0;

    always #10 clk = ~clk;

    irq_cause_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_evt(dev_evt),
        .mem_err_evt(mem_err_evt), .mem_err_addr(mem_err_addr),
        .stat_rd(stat_rd), .irq_out(irq_out)
    );

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:    return m_err[31:0];
            3'd1:    return m_err[63:32];
            3'd3:    return {30'b0, m_cause};
            3'd5:    return {30'b0, m_en};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [2:0] a);
        case (a)
            3'd0, 3'd1: return "R7";
            3'd3:       return "R2";
            3'd5:       return "R3";
            3'd7:       return "R4";
            default:    return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(input bit wr, input logic [2:0] a, input logic [31:0] wd,
                        input bit dv, input bit er, input logic [63:0] ea,
                        input bit sr, input string tag);
        logic [1:0] clr;
        @(negedge clk);
        check("R9", {63'b0, irq_out}, {63'b0, |(m_cause & m_en)});
        reg_wr = wr; reg_addr = a; reg_wdata = wd;
        dev_evt = dv; mem_err_evt = er; mem_err_addr = ea; stat_rd = sr;
        #1;
        check(tag, {32'b0, reg_rdata}, {32'b0, exp_read(a)});
        @(posedge clk);
        clr = (wr && a == 3'd7) ? wd[1:0] : 2'b00;
        if (er && !m_cause[1]) m_err = ea;
        if (wr && a == 3'd5) m_en = m_en | wd[1:0];
        m_cause[0] = dv | (m_cause[0] & ~clr[0] & ~sr);
        m_cause[1] = er | (m_cause[1] & ~clr[1]);
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        step(1'b0, a, 32'h0, 1'b0, 1'b0, 64'h0, 1'b0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; total++;
            $display("FAIL watchdog all actual=running expected=done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        rd(3'd0, "R1"); rd(3'd1, "R1"); rd(3'd3, "R1"); rd(3'd5, "R1");
        check("R1", {63'b0, irq_out}, 64'h0);
        // R2: drive event sets bit 0
        step(1'b0, 3'd3, 0, 1'b1, 1'b0, 0, 1'b0, "R2");
        rd(3'd3, "R2");
        // R3: enable bit 0; zero write leaves it
        step(1'b1, 3'd5, 32'h1, 1'b0, 1'b0, 0, 1'b0, "R3");
        rd(3'd5, "R3");
        step(1'b1, 3'd5, 32'hFFFF_FFFC, 1'b0, 1'b0, 0, 1'b0, "R3");
        rd(3'd5, "R3");
        // R6: side-effect read clears bit 0
        step(1'b0, 3'd3, 0, 1'b0, 1'b0, 0, 1'b1, "R6");
        rd(3'd3, "R6");
        // R7: first fault captured
        step(1'b0, 3'd3, 0, 1'b0, 1'b1, 64'h1234_5678_9ABC_DEF0, 1'b0, "R7");
        rd(3'd0, "R7"); rd(3'd1, "R7"); rd(3'd3, "R7");
        // R8: second fault does not replace address
        step(1'b0, 3'd0, 0, 1'b0, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 1'b0, "R8");
        rd(3'd0, "R8"); rd(3'd1, "R8");
        // R6: side-effect read keeps bit 1
        step(1'b0, 3'd3, 0, 1'b0, 1'b0, 0, 1'b1, "R6");
        rd(3'd3, "R6");
        // R5: event wins over clear in same cycle
        step(1'b1, 3'd7, 32'h3, 1'b1, 1'b0, 0, 1'b0, "R5");
        rd(3'd3, "R5");
        // R10: write to status and unused word ignored
        step(1'b1, 3'd3, 32'h3, 1'b0, 1'b0, 0, 1'b0, "R10");
        step(1'b1, 3'd6, 32'h3, 1'b0, 1'b0, 0, 1'b0, "R10");
        rd(3'd3, "R10"); rd(3'd5, "R10"); rd(3'd2, "R10");
        // R4: clear both
        step(1'b1, 3'd7, 32'h3, 1'b0, 1'b0, 0, 1'b0, "R4");
        rd(3'd3, "R4"); rd(3'd7, "R4");
        // R7: new fault captured after clear
        step(1'b0, 3'd3, 0, 1'b0, 1'b1, 64'h0F0F_0000_1111_2222, 1'b0, "R7");
        rd(3'd0, "R7"); rd(3'd1, "R7");
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [2:0] a;
            bit wr;
            a  = 3'($urandom);
            wr = ($urandom % 4) == 0;
            step(wr, a, ($urandom & 32'hFFFF_FFF0) | ($urandom % 4),
                 ($urandom % 8) == 0, ($urandom % 16) == 0,
                 {$urandom, $urandom}, ($urandom % 8) == 0, tag_of(a));
        end
        @(negedge clk);
        check("R9", {63'b0, irq_out}, {63'b0, |(m_cause & m_en)});
        finished = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule